// File: doc/BRIEF.md
# Shared Interrupt Router

This block gathers a parameterised set of external shared interrupt lines and delivers them to several cores. Each line first passes through a two-stage synchroniser. It is then conditioned by three per-line settings: an active-low inversion, a level/edge trigger select, and a both-edges select. Level lines report their live conditioned value as pending. Edge lines capture a detected edge in a latch that holds until software clears it.

A pending line reaches an output only if it is unmasked and has a route. Routing names one core and one pin of that core. Each core has one interrupt output per pin, and an output is the OR of every line that is pending, unmasked and routed to that core and pin.

Software reaches the settings through a word-wide register port. Per-line bits are packed 32 to a word. Masks change only through separate set and clear registers. A single software-edge register raises or drops any line's edge latch, which serves both inter-core signalling and edge acknowledgement.

Top module: `shint_router`

## Requirements
- R1: After reset every line is level-triggered, not inverted, not both-edges and masked; all routes are off, and every core output is low.
- R2: A write to the mask-set bank sets the mask enable of each line whose data bit is 1, and a write to the mask-clear bank clears it. Bits written as 0 leave their lines unchanged, and the mask readback bank returns the enables.
- R3: A level line (trigger bit 0) shows as pending the synchronised input, XORed with its inversion bit (1 = active low). A change on the input reaches the pending bank and the outputs after two clock edges.
- R4: An edge line (trigger bit 1) latches pending on a rising input when not inverted, or on a falling input when inverted. The latch holds until it is cleared through the software-edge register.
- R5: With the both-edges bit set, an edge line latches on either input transition, whatever its inversion bit.
- R6: A write to the software-edge bank sets the named line's edge latch when data bit 31 is 1 and clears it when bit 31 is 0. Bits [IW-1:0] carry the line number. The write does not change a level line's pending value.
- R7: If a detected edge and a software clear of the same line fall in the same cycle, the latch stays set.
- R8: Line n sits at bit n%32 of word n/32 in each per-line bit bank (word index = low address bits). Bits for lines at or beyond N_IRQ, and words past the last one, read 0.
- R9: Output bit c*N_PIN+p is high exactly when some line is pending and unmasked, has its pin-map enable (bit 31) set, has pin number p (low bits) and has core bit c set in its core map.
- R10: A core-map write keeps only the lowest set bit of data[N_CORE-1:0], so a line is routed to at most one core. A write of 0 unroutes it.
- R11: A read returns data with rd_valid on the cycle after the request. The config bank returns N_IRQ/8-1 in bits [7:0] and N_CORE-1 in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | Asynchronous shared interrupt lines |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4+IW | Bank in the top 4 bits (0 cfg, 1 invert, 2 trigger, 3 both-edges, 4 mask-set, 5 mask-clear, 6 mask, 7 pending, 8 soft-edge, 9 pin map, 10 core map), word or line index below |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| core_irq | output | N_CORE*N_PIN | Per-core, per-pin interrupt outputs |

## Verification
The functions that can meet in one cycle are the hardware edge detector and the software clear of that line's latch. The bench raises an edge line's input and times a software-edge clear so that the write lands on the very edge at which the detector fires. It then expects the line still pending and its routed output high, and a later clear with a quiet input must drop it. Mask set/clear isolation, inversion, both-edge mode and the one-hot core map are each driven with directed patterns and read back through the register port.

// File: rtl/shint_pkg.sv
package shint_pkg;

    localparam int BANK_W       = 4;
    localparam int SWE_SET_BIT  = 31;
    localparam int PIN_EN_BIT   = 31;

    typedef enum logic [BANK_W-1:0] {
        BK_CFG  = 4'd0,
        BK_INV  = 4'd1,
        BK_TRIG = 4'd2,
        BK_DUAL = 4'd3,
        BK_MSET = 4'd4,
        BK_MCLR = 4'd5,
        BK_MASK = 4'd6,
        BK_PEND = 4'd7,
        BK_SWE  = 4'd8,
        BK_PIN  = 4'd9,
        BK_CORE = 4'd10
    } bank_e;

    typedef struct packed {
        logic inv;
        logic edge_md;
        logic dual;
    } line_cfg_t;

    function automatic logic edge_detect(input line_cfg_t cfg, input logic cur, input logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (cfg.dual) return rise | fall;
        return cfg.inv ? fall : rise;
    endfunction

endpackage

// File: rtl/shint_line.sv
module shint_line
    import shint_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    input  line_cfg_t cfg,
    input  logic      swe_set,
    input  logic      swe_clr,
    output logic      pend,
    output logic      hit,
    output logic      lat
);
    logic [1:0] sync_q;
    logic       prev_q;

    assign hit  = edge_detect(cfg, sync_q[1], prev_q);
    assign pend = cfg.edge_md ? lat : (sync_q[1] ^ cfg.inv);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            lat    <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            prev_q <= sync_q[1];
            // a detected edge outranks a software clear in the same cycle
            lat    <= hit | swe_set | (lat & ~swe_clr);
        end
    end
endmodule

// File: rtl/shint_regs.sv
module shint_regs
    import shint_pkg::*;
#(
    parameter int N_IRQ  = 40,
    parameter int N_CORE = 2,
    parameter int N_PIN  = 4,
    parameter int IW     = 6
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                req_valid,
    input  logic                                req_write,
    input  logic [BANK_W+IW-1:0]                req_addr,
    input  logic [31:0]                         req_wdata,
    input  logic [N_IRQ-1:0]                    pend,
    output logic                                rd_valid,
    output logic [31:0]                         rd_data,
    output line_cfg_t [N_IRQ-1:0]               cfg,
    output logic [N_IRQ-1:0]                    mask,
    output logic [N_IRQ-1:0]                    pin_en,
    output logic [N_IRQ-1:0][$clog2(N_PIN)-1:0] pin_num,
    output logic [N_IRQ-1:0][N_CORE-1:0]        core_sel,
    output logic [N_IRQ-1:0]                    swe_set,
    output logic [N_IRQ-1:0]                    swe_clr
);
    localparam int NW = (N_IRQ + 31) / 32;
    localparam int PW = $clog2(N_PIN);
    localparam int AW = BANK_W + IW;

    bank_e            bank;
    logic [IW-1:0]    idx;
    logic             wr_en;
    logic             rd_en;
    logic [N_CORE-1:0] core_w;
    logic [31:0]      rd_next;
    logic [NW*32-1:0] pad_inv, pad_trig, pad_dual, pad_mask, pad_pend;

    assign bank   = bank_e'(req_addr[AW-1:IW]);
    assign idx    = req_addr[IW-1:0];
    assign wr_en  = req_valid & req_write;
    assign rd_en  = req_valid & ~req_write;
    assign core_w = req_wdata[N_CORE-1:0] & (~req_wdata[N_CORE-1:0] + 1'b1);

    always_comb begin
        for (int i = 0; i < N_IRQ; i++) begin
            swe_set[i] = wr_en && (bank == BK_SWE) && (req_wdata[IW-1:0] == IW'(i))
                         && req_wdata[SWE_SET_BIT];
            swe_clr[i] = wr_en && (bank == BK_SWE) && (req_wdata[IW-1:0] == IW'(i))
                         && !req_wdata[SWE_SET_BIT];
        end
    end

    always_comb begin
        int k;
        pad_inv  = '0;
        pad_trig = '0;
        pad_dual = '0;
        pad_mask = '0;
        pad_pend = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            pad_inv[i]  = cfg[i].inv;
            pad_trig[i] = cfg[i].edge_md;
            pad_dual[i] = cfg[i].dual;
            pad_mask[i] = mask[i];
            pad_pend[i] = pend[i];
        end
        k = int'(idx);
        rd_next = '0;
        case (bank)
            BK_CFG: begin
                rd_next[7:0]  = 8'(N_IRQ / 8 - 1);
                rd_next[15:8] = 8'(N_CORE - 1);
            end
            BK_INV:  if (k < NW) rd_next = pad_inv[k*32 +: 32];
            BK_TRIG: if (k < NW) rd_next = pad_trig[k*32 +: 32];
            BK_DUAL: if (k < NW) rd_next = pad_dual[k*32 +: 32];
            BK_MASK: if (k < NW) rd_next = pad_mask[k*32 +: 32];
            BK_PEND: if (k < NW) rd_next = pad_pend[k*32 +: 32];
            BK_PIN: if (k < N_IRQ) begin
                rd_next[PIN_EN_BIT] = pin_en[k];
                rd_next[PW-1:0]     = pin_num[k];
            end
            BK_CORE: if (k < N_IRQ) rd_next[N_CORE-1:0] = core_sel[k];
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            mask     <= '0;
            pin_en   <= '0;
            pin_num  <= '0;
            core_sel <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_next : '0;
            for (int i = 0; i < N_IRQ; i++) begin
                if (wr_en && idx == IW'(i / 32)) begin
                    case (bank)
                        BK_INV:  cfg[i].inv     <= req_wdata[i % 32];
                        BK_TRIG: cfg[i].edge_md <= req_wdata[i % 32];
                        BK_DUAL: cfg[i].dual    <= req_wdata[i % 32];
                        BK_MSET: if (req_wdata[i % 32]) mask[i] <= 1'b1;
                        BK_MCLR: if (req_wdata[i % 32]) mask[i] <= 1'b0;
                        default: ;
                    endcase
                end
                if (wr_en && idx == IW'(i)) begin
                    if (bank == BK_PIN) begin
                        pin_en[i]  <= req_wdata[PIN_EN_BIT];
                        pin_num[i] <= req_wdata[PW-1:0];
                    end
                    if (bank == BK_CORE) core_sel[i] <= core_w;
                end
            end
        end
    end
endmodule

// File: rtl/shint_route.sv
module shint_route #(
    parameter int N_IRQ  = 40,
    parameter int N_CORE = 2,
    parameter int N_PIN  = 4
) (
    input  logic [N_IRQ-1:0]                    pend,
    input  logic [N_IRQ-1:0]                    mask,
    input  logic [N_IRQ-1:0]                    pin_en,
    input  logic [N_IRQ-1:0][$clog2(N_PIN)-1:0] pin_num,
    input  logic [N_IRQ-1:0][N_CORE-1:0]        core_sel,
    output logic [N_CORE*N_PIN-1:0]             irq_out
);
    localparam int PW = $clog2(N_PIN);

    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        for (genvar p = 0; p < N_PIN; p++) begin : g_pin
            logic acc;
            always_comb begin
                acc = 1'b0;
                for (int i = 0; i < N_IRQ; i++) begin
                    acc = acc | (pend[i] & mask[i] & pin_en[i] & core_sel[i][c]
                                 & (pin_num[i] == PW'(p)));
                end
            end
            assign irq_out[c*N_PIN + p] = acc;
        end
    end
endmodule

// File: rtl/shint_router.sv
module shint_router
    import shint_pkg::*;
#(
    parameter int N_IRQ  = 40,
    parameter int N_CORE = 2,
    parameter int N_PIN  = 4,
    localparam int IW    = $clog2(N_IRQ),
    localparam int AW    = BANK_W + IW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_IRQ-1:0]         irq_in,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [AW-1:0]            req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     rd_valid,
    output logic [31:0]              rd_data,
    output logic [N_CORE*N_PIN-1:0]  core_irq
);
    localparam int PW = $clog2(N_PIN);

    line_cfg_t [N_IRQ-1:0]         cfg_w;
    logic [N_IRQ-1:0]              mask_w;
    logic [N_IRQ-1:0]              pin_en_w;
    logic [N_IRQ-1:0][PW-1:0]      pin_num_w;
    logic [N_IRQ-1:0][N_CORE-1:0]  core_sel_w;
    logic [N_IRQ-1:0]              swe_set_w, swe_clr_w;
    logic [N_IRQ-1:0]              pend_w, hit_w, lat_w;

    shint_regs #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_PIN(N_PIN), .IW(IW)) regs_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .pend(pend_w),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg(cfg_w), .mask(mask_w),
        .pin_en(pin_en_w), .pin_num(pin_num_w), .core_sel(core_sel_w),
        .swe_set(swe_set_w), .swe_clr(swe_clr_w)
    );

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        shint_line line_i (
            .clk(clk), .rst(rst),
            .raw(irq_in[i]), .cfg(cfg_w[i]),
            .swe_set(swe_set_w[i]), .swe_clr(swe_clr_w[i]),
            .pend(pend_w[i]), .hit(hit_w[i]), .lat(lat_w[i])
        );
    end

    shint_route #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_PIN(N_PIN)) route_i (
        .pend(pend_w), .mask(mask_w), .pin_en(pin_en_w),
        .pin_num(pin_num_w), .core_sel(core_sel_w),
        .irq_out(core_irq)
    );
endmodule

// File: rtl/shint_router_chk.sv
module shint_router_chk #(
    parameter int N_IRQ  = 40,
    parameter int N_CORE = 2,
    parameter int N_PIN  = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         req_valid,
    input logic                         req_write,
    input logic                         rd_valid,
    input logic [N_CORE*N_PIN-1:0]      core_irq,
    input logic [N_IRQ-1:0]             mask,
    input logic [N_IRQ-1:0]             hit,
    input logic [N_IRQ-1:0]             lat,
    input logic [N_IRQ-1:0]             swe_clr,
    input logic [N_IRQ-1:0][N_CORE-1:0] core_sel
);
    // R9
    route_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (|core_irq) |-> (|mask));

    // R11
    read_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        // R10
        core_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(core_sel[i]));

        // R7
        edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
            hit[i] |=> lat[i]);

        // R4
        latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (lat[i] && !swe_clr[i]) |=> lat[i]);

        // R6
        soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (swe_clr[i] && !hit[i]) |=> !lat[i]);
    end
endmodule

bind shint_router shint_router_chk #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_PIN(N_PIN)) chk_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .rd_valid(rd_valid),
    .core_irq(core_irq), .mask(mask_w), .hit(hit_w), .lat(lat_w),
    .swe_clr(swe_clr_w), .core_sel(core_sel_w)
);

// File: tb/shint_router_tb_top.sv
module shint_router_tb_top;
    localparam int N_IRQ  = 40;
    localparam int N_CORE = 2;
    localparam int N_PIN  = 4;
    localparam int IW     = 6;
    localparam int AW     = 4 + IW;

    localparam int B_CFG = 0, B_INV = 1, B_TRIG = 2, B_DUAL = 3, B_MSET = 4,
                   B_MCLR = 5, B_MASK = 6, B_PEND = 7, B_SWE = 8, B_PIN = 9, B_CORE = 10;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [N_IRQ-1:0]        irq_in = '0;
    logic                    req_valid = 1'b0;
    logic                    req_write = 1'b0;
    logic [AW-1:0]           req_addr = '0;
    logic [31:0]             req_wdata = '0;
    logic                    rd_valid;
    logic [31:0]             rd_data;
    logic [N_CORE*N_PIN-1:0] core_irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    shint_router #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_PIN(N_PIN)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .core_irq(core_irq)
    );

    function automatic logic [AW-1:0] ad(input int bank, input int idx);
        return {4'(bank), IW'(idx)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int j = 0; j < n; j++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input int bank, input int idx, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ad(bank, idx); req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int bank, input int idx, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = ad(bank, idx);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_valid ? rd_data : 32'hDEAD_BEEF;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 outputs low", 32'(core_irq), 32'h0);
        rd(B_MASK, 0, d); chk("R1 mask word0", d, 32'h0);
        rd(B_TRIG, 0, d); chk("R1 trigger word0", d, 32'h0);
        rd(B_INV, 1, d);  chk("R1 invert word1", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(B_MSET, 0, 32'h0000_00F5);
        rd(B_MASK, 0, d); chk("R2 mask set", d, 32'h0000_00F5);
        wr(B_MCLR, 0, 32'h0000_0005);
        rd(B_MASK, 0, d); chk("R2 mask clear keeps zeros", d, 32'h0000_00F0);
        wr(B_MSET, 1, 32'hFFFF_FFFF);
        rd(B_MASK, 1, d); chk("R8 mask word1 width", d, 32'h0000_00FF);
        rd(B_MASK, 2, d); chk("R8 word past end", d, 32'h0);
        wr(B_MCLR, 0, 32'hFFFF_FFFF);
        wr(B_MCLR, 1, 32'hFFFF_FFFF);
        rd(B_MASK, 1, d); chk("R2 mask cleared", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(B_PIN, 3, 32'h8000_0002);
        wr(B_CORE, 3, 32'h2);
        irq_in[3] = 1'b1;
        tick(3);
        chk("R9 masked line silent", 32'(core_irq), 32'h0);
        wr(B_MSET, 0, 32'h8);
        chk("R9 route core1 pin2", 32'(core_irq), 32'h40);
        rd(B_PEND, 0, d); chk("R3 level pending", d, 32'h8);
        rd(B_PIN, 3, d);  chk("R9 pin readback", d, 32'h8000_0002);
        wr(B_INV, 0, 32'h8);
        rd(B_PEND, 0, d); chk("R3 inverted level", d, 32'h0);
        chk("R3 inverted output", 32'(core_irq), 32'h0);
        irq_in[3] = 1'b0;
        tick(3);
        chk("R3 active low asserts", 32'(core_irq), 32'h40);
        wr(B_INV, 0, 32'h0);
        chk("R3 back to positive", 32'(core_irq), 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(B_TRIG, 0, 32'h20);
        wr(B_PIN, 5, 32'h8000_0000);
        wr(B_CORE, 5, 32'h1);
        wr(B_MSET, 0, 32'h20);
        irq_in[5] = 1'b1; tick(3);
        irq_in[5] = 1'b0; tick(3);
        rd(B_PEND, 0, d); chk("R4 rising edge held", d, 32'h20);
        chk("R4 edge routed core0 pin0", 32'(core_irq), 32'h01);
        wr(B_SWE, 0, 32'h0000_0005);
        rd(B_PEND, 0, d); chk("R6 soft clear", d, 32'h0);
        wr(B_INV, 0, 32'h20);
        irq_in[5] = 1'b1; tick(4);
        rd(B_PEND, 0, d); chk("R4 inverted ignores rise", d, 32'h0);
        irq_in[5] = 1'b0; tick(4);
        rd(B_PEND, 0, d); chk("R4 inverted falling edge", d, 32'h20);
        wr(B_SWE, 0, 32'h0000_0005);
    endtask

    task automatic t_dual();
        logic [31:0] d;
        wr(B_TRIG, 0, 32'hA0);
        wr(B_DUAL, 0, 32'h80);
        wr(B_INV, 0, 32'h80);
        irq_in[7] = 1'b1; tick(4);
        rd(B_PEND, 0, d); chk("R5 rise with invert", d, 32'h80);
        wr(B_SWE, 0, 32'h0000_0007);
        rd(B_PEND, 0, d); chk("R5 cleared", d, 32'h0);
        irq_in[7] = 1'b0; tick(4);
        rd(B_PEND, 0, d); chk("R5 fall", d, 32'h80);
        wr(B_SWE, 0, 32'h0000_0007);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(B_TRIG, 1, 32'h8);
        wr(B_SWE, 0, 32'h8000_0023);
        rd(B_PEND, 1, d); chk("R6 soft set line35 word1", d, 32'h8);
        wr(B_SWE, 0, 32'h8000_0009);
        rd(B_PEND, 0, d); chk("R6 level line ignores soft set", d, 32'h0);
        wr(B_SWE, 0, 32'h0000_0009);
        wr(B_SWE, 0, 32'h0000_0023);
        rd(B_PEND, 1, d); chk("R6 soft clear line35", d, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(B_INV, 0, 32'h0);
        irq_in[5] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        wr(B_SWE, 0, 32'h0000_0005);
        tick(1);
        rd(B_PEND, 0, d); chk("R7 edge beats clear", d, 32'h20);
        chk("R7 output stays", 32'(core_irq), 32'h01);
        wr(B_SWE, 0, 32'h0000_0005);
        rd(B_PEND, 0, d); chk("R7 later clear", d, 32'h0);
        irq_in[5] = 1'b0; tick(3);
    endtask

    task automatic t_core();
        logic [31:0] d;
        wr(B_CORE, 10, 32'h3);
        rd(B_CORE, 10, d); chk("R10 lowest bit kept", d, 32'h1);
        wr(B_CORE, 10, 32'h2);
        rd(B_CORE, 10, d); chk("R10 core1", d, 32'h2);
        wr(B_CORE, 10, 32'h0);
        rd(B_CORE, 10, d); chk("R10 unrouted", d, 32'h0);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        rd(B_CFG, 0, d); chk("R11 config", d, 32'h0000_0104);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_mask();
        t_level();
        t_edge();
        t_dual();
        t_soft();
        t_collide();
        t_core();
        t_cfg();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule